// File: doc/BRIEF.md
# Watchdog Timer with Prescaled Tick Sources

This block is a watchdog built around a 16-bit up-counter. It sits on a small 32-bit register bus with four word-spaced registers. The counter advances on ticks from one of three tick-enable inputs: a peripheral-clock tick, a 32.768 kHz real-time tick and an external tick. All three arrive already sampled into the system clock domain. A prescaler between the selected tick and the counter divides by a power of four, from 1 to 1024.

When the count is due to advance while it equals the programmed compare value, the count wraps to zero and a one-cycle reset request is raised. A system reset generator outside the block takes that request. Software arms the watchdog through a single enable bit. It can read the live count at any time and can write the count to restart the timeout. Source and ratio settings are frozen while the watchdog runs.

Top module: `wdt_top`

## Requirements
- R1: After a synchronous reset, every register reads 0 and `rst_req` is low.
- R2: Registers are selected by bus_addr[3:2]. Word 0 holds the compare value in bits 15:0, word 1 holds the enable flag in bit 0, word 2 holds the live count in bits 15:0, and word 3 holds the control value in bits 5:0. Every unused read bit is 0.
- R3: The counter advances only while the enable flag is 1. Clearing the flag freezes the count.
- R4: Control bit 0 selects the peripheral tick, bit 1 the real-time tick and bit 2 the external tick. When several of these bits are set, the lowest set bit wins. When none is set, the counter never advances.
- R5: Control bits 5:3 set the prescale ratio. Codes 0 to 5 give one counter step per 1, 4, 16, 64, 256 and 1024 selected ticks. Codes 6 and 7 behave as 1024.
- R6: When a counter step falls while the count equals the compare value, the count becomes 0 at that clock edge. `rst_req` is high for exactly the following cycle.
- R7: A counter step from 0xFFFF gives 0 without a reset request when the compare value differs from 0xFFFF.
- R8: Writing word 2 loads the count from bits 15:0 and clears the prescaler phase. In the same cycle, the load takes priority over a counter step.
- R9: A write to word 3 is ignored while the enable flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 4 | Byte offset; bits 3:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| tick_pclk | input | 1 | Peripheral-clock tick enable |
| tick_rtc | input | 1 | Real-time-clock tick enable |
| tick_ext | input | 1 | External-clock tick enable |
| rst_req | output | 1 | One-cycle reset request on compare hit |

## Verification
Register writes and counter steps take effect at the clock edge where the strobe or tick is high. Read data follows the address combinationally, so a read is due half a cycle after the address is driven. The reset request is registered and becomes visible on the half cycle after the edge that took the final step, then drops one cycle later. The driver pushes each expectation into a queue in the half cycle where it is due. The monitor pops and compares it two nanoseconds after the falling edge, away from the sampling edge. The ticks are held low during reads and writes, so each check sees an exact count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int BUS_W  = 32;
    localparam int CNT_W  = 16;
    localparam int SRC_N  = 3;
    localparam int DIV_W  = 3;
    localparam int PH_W   = 10;
    localparam int DIV_MAX = 5;

    typedef enum logic [1:0] {
        W_CMP  = 2'd0,
        W_EN   = 2'd1,
        W_CNT  = 2'd2,
        W_CTRL = 2'd3
    } wdt_reg_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [SRC_N-1:0] src;
    } wdt_ctrl_t;

    localparam int CTRL_W = $bits(wdt_ctrl_t);

    // Terminal phase value for a prescale code: 4**code - 1, saturated.
    function automatic logic [PH_W-1:0] div_last(input logic [DIV_W-1:0] code);
        int c;
        c = (int'(code) > DIV_MAX) ? DIV_MAX : int'(code);
        return PH_W'((32'd1 << (2 * c)) - 32'd1);
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              en_o,
    output wdt_ctrl_t         ctrl_o,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o
);

    wdt_reg_e  word;
    logic      wr;
    logic [CNT_W-1:0] cmp_q;
    logic      en_q;
    wdt_ctrl_t ctrl_q;

    assign word = wdt_reg_e'(bus_addr[3:2]);
    assign wr   = bus_sel && bus_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            en_q   <= 1'b0;
            ctrl_q <= '0;
        end else if (wr) begin
            case (word)
                W_CMP:   cmp_q <= bus_wdata[CNT_W-1:0];
                W_EN:    en_q  <= bus_wdata[0];
                W_CTRL:  if (!en_q) ctrl_q <= wdt_ctrl_t'(bus_wdata[CTRL_W-1:0]);
                default: ;
            endcase
        end
    end

    assign load_o     = wr && (word == W_CNT);
    assign load_val_o = bus_wdata[CNT_W-1:0];
    assign cmp_o      = cmp_q;
    assign en_o       = en_q;
    assign ctrl_o     = ctrl_q;

    always_comb begin
        bus_rdata = '0;
        case (word)
            W_CMP:  bus_rdata[CNT_W-1:0]  = cmp_q;
            W_EN:   bus_rdata[0]          = en_q;
            W_CNT:  bus_rdata[CNT_W-1:0]  = cnt_i;
            W_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
            default: ;
        endcase
    end

    // R9
    ctrl_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q && wr && word == W_CTRL) |=> $stable(ctrl_q));

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  wdt_ctrl_t        ctrl_i,
    input  logic [SRC_N-1:0] ticks_i,
    input  logic             load_i,
    output logic             step_o
);

    logic [SRC_N-1:0] pick;
    logic             tick_sel;
    logic [PH_W-1:0]  phase_q;
    logic [PH_W-1:0]  last;

    genvar gi;
    generate
        for (gi = 0; gi < SRC_N; gi++) begin : g_pick
            if (gi == 0) begin : g_first
                assign pick[gi] = ctrl_i.src[gi];
            end else begin : g_rest
                assign pick[gi] = ctrl_i.src[gi] & ~(|ctrl_i.src[gi-1:0]);
            end
        end
    endgenerate

    assign tick_sel = |(pick & ticks_i);
    assign last     = div_last(ctrl_i.div);
    assign step_o   = en_i && tick_sel && (phase_q == last) && !load_i;

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            phase_q <= '0;
        end else if (en_i && tick_sel) begin
            phase_q <= (phase_q == last) ? '0 : phase_q + 1'b1;
        end
    end

    // R8
    load_phase_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (phase_q == '0));

    // R4
    step_src_chk: assert property (@(posedge clk) disable iff (rst)
        step_o |-> (|(ctrl_i.src & ticks_i)));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             req_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             req_q;
    logic             hit;

    assign hit = step_i && (cnt_q == cmp_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            req_q <= hit && !load_i;
            if (load_i)      cnt_q <= load_val_i;
            else if (hit)    cnt_q <= '0;
            else if (step_i) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
    assign req_o = req_q;

    // R6
    req_zero_chk: assert property (@(posedge clk) disable iff (rst)
        req_q |-> (cnt_q == '0));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !step_i) |=> $stable(cnt_q));

    // R7
    incr_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && cnt_q != cmp_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R8
    load_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_pclk,
    input  logic              tick_rtc,
    input  logic              tick_ext,
    output logic              rst_req
);

    logic [CNT_W-1:0] cnt, cmp, load_val;
    logic             en, load, step;
    wdt_ctrl_t        ctrl;
    logic [SRC_N-1:0] ticks;

    assign ticks = {tick_ext, tick_rtc, tick_pclk};

    wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_i(cnt), .cmp_o(cmp), .en_o(en), .ctrl_o(ctrl),
        .load_o(load), .load_val_o(load_val)
    );

    wdt_prescaler u_pre (
        .clk(clk), .rst(rst), .en_i(en), .ctrl_i(ctrl),
        .ticks_i(ticks), .load_i(load), .step_o(step)
    );

    wdt_counter u_cnt (
        .clk(clk), .rst(rst), .load_i(load), .load_val_i(load_val),
        .step_i(step), .cmp_i(cmp), .cnt_o(cnt), .req_o(rst_req)
    );

    // R3
    step_en_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> en);

endmodule

// File: tb/test_wdt_top.sv
module test_wdt_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_pclk = 1'b0, tick_rtc = 1'b0, tick_ext = 1'b0;
    logic        rst_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_req;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #10 clk = ~clk;

    wdt_top i_wdt_top (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_pclk(tick_pclk), .tick_rtc(tick_rtc), .tick_ext(tick_ext),
        .rst_req(rst_req)
    );

    // Monitor: compares due items two ns after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it = sb.pop_front();
                got = it.is_req ? {31'd0, rst_req} : bus_rdata;
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        sb.push_back('{1'b0, e, tag});
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic exp_req(input logic v, input string tag);
        sb.push_back('{1'b1, {31'd0, v}, tag});
        @(negedge clk);
    endtask

    task automatic ticks(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            tick_pclk = (which & 1) != 0;
            tick_rtc  = (which & 2) != 0;
            tick_ext  = (which & 4) != 0;
            @(negedge clk);
        end
        tick_pclk = 1'b0; tick_rtc = 1'b0; tick_ext = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values (R2 map)
        rd(4'h0, 32'h0, "R1 cmp");
        rd(4'h4, 32'h0, "R1 en");
        rd(4'h8, 32'h0, "R1 cnt");
        rd(4'hC, 32'h0, "R1 ctrl");
        exp_req(1'b0, "R1 rst_req");

        // R2 readback; /1 on peripheral tick
        wr(4'hC, 32'hFFFF_FFC1);
        rd(4'hC, 32'h0000_0001, "R2 ctrl bits");
        wr(4'h0, 32'hABCD_0005);
        rd(4'h0, 32'h0000_0005, "R2 cmp bits");
        wr(4'h8, 32'h0);
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, 32'h1, "R2 en bit");
        ticks(1, 3);
        rd(4'h8, 32'd3, "R5 div1 count");
        // R9 control frozen while enabled
        wr(4'hC, 32'h3A);
        rd(4'hC, 32'h01, "R9 ctrl ignored");
        // R6 compare hit
        ticks(1, 2);
        rd(4'h8, 32'd5, "R6 at compare");
        exp_req(1'b0, "R6 no early req");
        ticks(1, 1);
        exp_req(1'b1, "R6 req high");
        exp_req(1'b0, "R6 req one cycle");
        rd(4'h8, 32'd0, "R6 wrapped");

        // R3 disable freezes
        ticks(1, 2);
        wr(4'h4, 32'h0);
        ticks(1, 4);
        rd(4'h8, 32'd2, "R3 frozen");

        // R4 priority: rtc + ext set, rtc wins
        wr(4'hC, 32'h06);
        wr(4'h8, 32'h0);
        wr(4'h4, 32'h1);
        ticks(4, 3);
        rd(4'h8, 32'd0, "R4 ext masked");
        ticks(2, 2);
        rd(4'h8, 32'd2, "R4 rtc counts");

        // R5 /4 on external tick
        wr(4'h4, 32'h0);
        wr(4'hC, 32'h0C);
        wr(4'h8, 32'h0);
        wr(4'h4, 32'h1);
        ticks(4, 3);
        rd(4'h8, 32'd0, "R5 div4 partial");
        ticks(4, 1);
        rd(4'h8, 32'd1, "R5 div4 first");
        ticks(4, 4);
        rd(4'h8, 32'd2, "R5 div4 second");
        // R8 load clears phase
        ticks(4, 2);
        wr(4'h8, 32'h0010);
        ticks(4, 3);
        rd(4'h8, 32'h10, "R8 phase cleared");
        ticks(4, 1);
        rd(4'h8, 32'h11, "R8 step after load");

        // R5 /16
        wr(4'h4, 32'h0);
        wr(4'hC, 32'h11);
        wr(4'h8, 32'h0);
        wr(4'h4, 32'h1);
        ticks(1, 15);
        rd(4'h8, 32'd0, "R5 div16 partial");
        ticks(1, 1);
        rd(4'h8, 32'd1, "R5 div16 first");

        // R5 code 7 acts as /1024
        wr(4'h4, 32'h0);
        wr(4'hC, 32'h39);
        wr(4'h8, 32'h0);
        wr(4'h4, 32'h1);
        ticks(1, 1023);
        rd(4'h8, 32'd0, "R5 code7 partial");
        ticks(1, 1);
        rd(4'h8, 32'd1, "R5 code7 first");

        // R4 no source selected
        wr(4'h4, 32'h0);
        wr(4'hC, 32'h00);
        wr(4'h4, 32'h1);
        ticks(7, 5);
        rd(4'h8, 32'd1, "R4 no source");

        // R7 wrap past 0xFFFF without request
        wr(4'h4, 32'h0);
        wr(4'hC, 32'h01);
        wr(4'h8, 32'hFFFF);
        wr(4'h4, 32'h1);
        ticks(1, 1);
        exp_req(1'b0, "R7 no req on wrap");
        rd(4'h8, 32'd0, "R7 wrapped to zero");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule